// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block times the high and low halves of each SCL period for an I2C master. A sequencer asks for a new phase at every SCL edge it makes. The timer then loads a 7-bit duration taken from a configuration byte and counts down to zero at half the system clock rate. When the count reaches zero, the timer sends the sequencer a single-cycle terminal pulse. After that the count stays at zero until the next load.

When the master has released SCL, a slave may still be holding the line low to stretch the clock. In that case the timer does not load. It waits, with a visible waiting flag, until the resynchronised SCL line is seen high, and only then starts timing the high phase.

A duration of zero is raised to one count, so no phase ever has zero length. Clearing the enable input holds the whole timer at rest.

Top module: `i2c_baud_gen`

## Requirements
- R1: A load takes its duration from bits 6..0 of `cfg_reg`. Bit 7 has no effect. One cycle after the load edge, `count_value` equals that duration.
- R2: After a load at clock edge k, the count drops by one at edges k+2, k+4 and so on. The count therefore reaches zero after edge k+2N.
- R3: At zero the count holds. No further `tc_pulse` appears until the next load.
- R4: `tc_pulse` is high for exactly one cycle. That cycle is the first cycle in which `count_value` is zero after a load.
- R5: A request made while `scl_release`=1 and the synchronised SCL is low does not load. While it waits, `stretch_wait`=1 and `count_value` keeps its previous value.
- R6: `scl_in` passes through two flops before it is used. A load that is waiting for SCL takes place on the third clock edge after `scl_in` rises.
- R7: A request made while `scl_release`=0 loads on the next clock edge, whatever the level of `scl_in`.
- R8: A duration field of 0 loads as 1, so the terminal pulse follows the load by two cycles.
- R9: While `enable`=0, the count is 0 from the next edge on, `tc_pulse` and `stretch_wait` are 0, and load requests have no effect.
- R10: After reset, `count_value`=0, `tc_pulse`=0 and `stretch_wait`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master mode enable; low holds the timer cleared |
| cfg_reg | input | 8 | Configuration byte; bits 6..0 give the phase duration |
| phase_load | input | 1 | One-cycle request from the sequencer at an SCL phase boundary |
| scl_release | input | 1 | 1 when the master is releasing SCL (high phase), 0 when it drives SCL low |
| scl_in | input | 1 | Raw SCL line level |
| count_value | output | 7 | Current down-counter value |
| tc_pulse | output | 1 | One-cycle pulse when the count reaches zero |
| stretch_wait | output | 1 | A load is pending until SCL is seen high |

## Verification
The embedded assertions check several properties on every cycle: the count holds at zero, the terminal pulse is one cycle wide and coincides with a zero count, decrement ticks are never adjacent, a loaded value is never zero and matches the duration field, and disable clears the count. Other behaviours can only be shown by the bench's scenarios. These are the exact number of cycles from a request to the terminal pulse, the three-edge delay through the synchroniser during stretching, the masking of configuration bit 7, and the absence of a load while disabled.

// File: rtl/i2c_bg_pkg.sv
package i2c_bg_pkg;

  typedef enum logic [0:0] {
    BG_IDLE = 1'b0,
    BG_HOLD = 1'b1
  } bg_state_t;

  // Duration field to load value: never below one.
  function automatic int unsigned bg_floor_one(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

  // True when this step takes the count from one to zero.
  function automatic logic bg_is_last(input int unsigned count);
    return count == 1;
  endfunction

endpackage

// File: rtl/bg_phase_tick.sv
module bg_phase_tick #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic restart,
  output logic tick
);
  localparam int PH_W = (PHASES > 2) ? $clog2(PHASES) : 1;
  localparam int HALF = PHASES / 2;

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (clr || restart)    phase_q <= '0;
    else if (phase_q == PH_W'(PHASES - 1)) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  // Two count steps per instruction period: the last phase of each half.
  always_comb tick = (int'(phase_q) % HALF) == (HALF - 1);

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !clr) |=> !tick);

endmodule

// File: rtl/bg_scl_sync.sv
module bg_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/bg_downcounter.sv
module bg_downcounter
  import i2c_bg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             tc
);
  logic [CNT_W-1:0] count_q;
  logic             tc_q;
  logic             step;

  always_comb step = tick && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else if (clr) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      tc_q    <= 1'b0;
    end else if (step) begin
      count_q <= count_q - 1'b1;
      tc_q    <= bg_is_last(int'(count_q));
    end else begin
      tc_q    <= 1'b0;
    end
  end

  assign count = count_q;
  assign tc    = tc_q;

  assert_load_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> count_q == $past(load_val));
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load) |=> count_q == '0);
  assert_tc_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  assert_tc_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> count_q == '0);
  assert_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr) |=> $stable(count_q));

endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen
  import i2c_bg_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int PHASES      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfg_reg,
  input  logic             phase_load,
  input  logic             scl_release,
  input  logic             scl_in,
  output logic [CNT_W-1:0] count_value,
  output logic             tc_pulse,
  output logic             stretch_wait
);
  bg_state_t        state_q;
  logic             scl_hi;
  logic             reload_evt;
  logic             tick;
  logic [CNT_W-1:0] load_val;
  logic             unused_cfg;

  assign unused_cfg = ^cfg_reg[CFG_W-1:CNT_W];

  always_comb load_val = CNT_W'(bg_floor_one(int'(cfg_reg[CNT_W-1:0])));

  bg_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_hi)
  );

  // Load when asked (now or earlier) and SCL is either driven low or seen high.
  always_comb reload_evt = enable && (phase_load || state_q == BG_HOLD)
                           && (!scl_release || scl_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state_q <= BG_IDLE;
    else if (!enable)     state_q <= BG_IDLE;
    else if (reload_evt)  state_q <= BG_IDLE;
    else if (phase_load)  state_q <= BG_HOLD;
  end

  bg_phase_tick #(.PHASES(PHASES)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .restart(reload_evt), .tick(tick)
  );

  bg_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .load(reload_evt),
    .load_val(load_val), .tick(tick), .count(count_value), .tc(tc_pulse)
  );

  assign stretch_wait = (state_q == BG_HOLD);

  assert_nonzero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> count_value != '0);
  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count_value == '0 && !tc_pulse && !stretch_wait));
  assert_wait_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_wait && scl_release && !scl_hi && enable) |=> $stable(count_value) || $past(tick));

endmodule

// File: tb/i2c_baud_gen_test.sv
module i2c_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] cfg_reg = 8'h00;
  logic       phase_load = 1'b0;
  logic       scl_release = 1'b0;
  logic       scl_in = 1'b0;
  logic [6:0] count_value;
  logic       tc_pulse;
  logic       stretch_wait;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  i2c_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_reg(cfg_reg),
    .phase_load(phase_load), .scl_release(scl_release), .scl_in(scl_in),
    .count_value(count_value), .tc_pulse(tc_pulse), .stretch_wait(stretch_wait)
  );

  // {cfg, release, stretch cycles, expected edges from request to terminal pulse}
  localparam logic [31:0] VEC [8] = '{
    {8'h05, 8'd0, 8'd0,  8'd11},
    {8'h85, 8'd0, 8'd0,  8'd11},
    {8'h00, 8'd0, 8'd0,  8'd3},
    {8'h01, 8'd0, 8'd0,  8'd3},
    {8'h03, 8'd1, 8'd0,  8'd9},
    {8'h03, 8'd1, 8'd4,  8'd13},
    {8'h7F, 8'd0, 8'd0,  8'd255},
    {8'h02, 8'd1, 8'd10, 8'd17}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int dur(input logic [7:0] c);
    return (c[6:0] == 7'd0) ? 1 : int'(c[6:0]);
  endfunction

  task automatic settle_low();
    scl_release = 1'b0;
    scl_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Runs one phase; returns edges from request to the terminal pulse.
  task automatic run_phase(input logic [7:0] c, input logic rel, input int s,
                           output int edges);
    int n = dur(c);
    int load_edge = rel ? s + 3 : 1;
    edges = 0;
    cfg_reg = c;
    scl_release = rel;
    scl_in = rel ? (s == 0) : 1'b0;
    phase_load = 1'b1;
    while (edges < 400) begin
      @(negedge clk);
      edges++;
      if (edges == 1) phase_load = 1'b0;
      if (rel && s > 0 && edges == s) scl_in = 1'b1;
      if (rel && edges == 1) begin
        check("R5 wait flag", stretch_wait, 1);
        check("R5 count held", count_value, 0);
      end
      if (edges == load_edge) check("R1/R6/R7 loaded value", count_value, n);
      if (tc_pulse) break;
    end
    @(negedge clk);
    check("R4 pulse width", tc_pulse, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int e;
    int pulses;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 count", count_value, 0);
    check("R10 tc", tc_pulse, 0);
    check("R10 wait", stretch_wait, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    settle_low();

    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_phase(v[31:24], v[16], int'(v[15:8]), e);
      check($sformatf("R2/R6/R8 vector %0d edges", i), e, int'(v[7:0]));
      settle_low();
    end

    // R3: hold at zero, no second pulse
    run_phase(8'h04, 1'b0, 0, e);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (tc_pulse) pulses++;
    end
    check("R3 no repeat pulse", pulses, 0);
    check("R3 count stays zero", count_value, 0);

    // R9: disable mid-count clears, requests ignored
    cfg_reg = 8'd20;
    phase_load = 1'b1;
    @(negedge clk);
    phase_load = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 count cleared", count_value, 0);
    phase_load = 1'b1;
    @(negedge clk);
    phase_load = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 request ignored", count_value, 0);
    check("R9 no wait", stretch_wait, 0);
    check("R9 no pulse", tc_pulse, 0);
    enable = 1'b1;
    settle_low();

    // R7: low phase loads next edge even with SCL high
    scl_in = 1'b1;
    run_phase(8'h06, 1'b0, 0, e);
    check("R7 edges with scl high", e, 13);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule